// File: doc/BRIEF.md
# Energy-Efficient Ethernet Transmit Low-Power Idle Controller

This block decides when the transmit side of an Ethernet MAC may drop into low-power idle and when it must come back out. Software provides an enable bit, an automatic-entry bit and a link-good flag. Software also provides two timer settings: a link-stable time in milliseconds and a wake hold-off in microseconds. The transmit path reports whether data is waiting. A free-running microsecond tick supplies the time base. A prescaler inside the block divides the tick down to milliseconds.

The controller is a three-state machine:
- `ST_ACTIVE`: normal transmission.
- `ST_LPI`: low-power idle is being signalled.
- `ST_WAKE`: the hold-off after idle signalling stops.

The transitions are:
- **enter** (`ST_ACTIVE` to `ST_LPI`): enable and auto are both set, the link has been good for at least the link-stable time, and nothing is pending.
- **leave** (`ST_LPI` to `ST_WAKE`): data becomes pending, enable or auto is cleared, or the link drops.
- **resume** (`ST_WAKE` to `ST_ACTIVE`): the wake counter has run out.

Every entry and exit of the transmit path is latched in a four-bit event register. The same register latches the entry and exit pulses reported by the receive path. A status read clears the register. An interrupt is asserted while any event bit is held.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset the controller is in `ST_ACTIVE`: `tx_ready`=1, `tx_lpi`=0, `lpi_events`=0 and `lpi_irq`=0.
- R2: Entry into idle requires the link to have been good for at least `ls_ms` milliseconds, where one millisecond is `US_PER_MS` ticks of `us_tick`. The move to idle happens on the clock edge after the tick that completes the count. With `ls_ms`=0, entry needs no wait.
- R3: The enter transition is taken only when `lpi_en`=1, `lpi_auto`=1, `link_up`=1 and `tx_pending`=0. If any of these does not hold, the controller stays in `ST_ACTIVE`.
- R4: In `ST_LPI`, `tx_pending`=1 causes the leave transition on the next edge. `tx_ready` then stays 0 until `tw_us` ticks of `us_tick` have been counted in `ST_WAKE`. It returns to 1 on the edge after the tick that brings the count to zero.
- R5: In `ST_LPI`, clearing `lpi_en` or dropping `link_up` forces the leave transition on the next edge and records a transmit-exit event.
- R6: Whenever `link_up` is 0, the link-stable count restarts from zero, including the partial millisecond.
- R7: Event bit positions are: bit 0 = transmit entered idle, bit 1 = transmit left idle, bit 2 = receive entered idle (`rx_lpi_enter` pulse), bit 3 = receive left idle (`rx_lpi_exit` pulse). `lpi_irq` is 1 exactly while any event bit is 1.
- R8: A cycle with `stat_rd`=1 clears all event bits on the next edge. An event that arrives in that same cycle is kept set.
- R9: With `tw_us`=0, `ST_WAKE` lasts exactly one clock, during which `tx_ready`=0.
- R10: `tx_lpi` is 1 exactly in `ST_LPI`. `tx_ready` is 1 exactly in `ST_ACTIVE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| lpi_en | input | 1 | Software enable for low-power idle |
| lpi_auto | input | 1 | Software permission for automatic entry/exit |
| link_up | input | 1 | Software-written PHY link-good flag |
| ls_ms | input | 11 | Link-stable time in milliseconds |
| tw_us | input | 16 | Wake hold-off in microseconds |
| tx_pending | input | 1 | Transmit data is waiting |
| rx_lpi_enter | input | 1 | Receive path entered idle (pulse) |
| rx_lpi_exit | input | 1 | Receive path left idle (pulse) |
| stat_rd | input | 1 | Status read strobe; clears events |
| tx_lpi | output | 1 | Transmit path is signalling idle |
| tx_ready | output | 1 | Transmission permitted |
| lpi_events | output | 4 | Latched event bits |
| lpi_irq | output | 1 | Event interrupt |

## Verification
The entry gate is swept over all eight combinations of enable, auto and pending, with the link held good. Only the all-permitting combination may reach idle, so each gating input is shown to matter on its own. Link-stable timing is checked one tick short of the limit and exactly at it, both on a fresh link and after a link drop. This separates a count that restarts from one that carries over. Wake hold-off is tried with a nonzero value and with zero, which tells the tick count apart from a fixed one-cycle wake. Reads are tried with and without a colliding event to fix the set-over-clear priority.

// File: rtl/eee_pkg.sv
package eee_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LPI    = 2'd1,
        ST_WAKE   = 2'd2
    } lpi_state_e;

    localparam int EV_TX_ENTER = 0;
    localparam int EV_TX_EXIT  = 1;
    localparam int EV_RX_ENTER = 2;
    localparam int EV_RX_EXIT  = 3;
    localparam int EV_NUM      = 4;
endpackage

// File: rtl/eee_ls_timer.sv
module eee_ls_timer #(
    parameter int US_PER_MS = 1000,
    parameter int LS_W      = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            link_up,
    input  logic [LS_W-1:0] ls_ms,
    output logic            ls_met
);
    localparam int PW = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
    localparam logic [PW-1:0]   PRE_LAST = PW'(US_PER_MS - 1);
    localparam logic [LS_W-1:0] MS_MAX   = '1;

    logic [PW-1:0]   pre_q;
    logic [LS_W-1:0] ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (!link_up) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (us_tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                if (ms_q != MS_MAX) ms_q <= ms_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign ls_met = link_up && (ms_q >= ls_ms);

    // R6
    ls_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (ms_q == '0 && pre_q == '0));
endmodule

// File: rtl/eee_wake_timer.sv
module eee_wake_timer #(
    parameter int TW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            load,
    input  logic [TW_W-1:0] load_val,
    output logic            done
);
    logic [TW_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load)                   cnt_q <= load_val;
        else if (us_tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R4
    wake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/eee_event_reg.sv
module eee_event_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic         clr,
    output logic [N-1:0] ev,
    output logic         irq
);
    logic [N-1:0] ev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ev_q <= '0;
        else if (clr) ev_q <= set_v;
        else          ev_q <= ev_q | set_v;
    end

    assign ev  = ev_q;
    assign irq = |ev_q;

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((ev_q & ~$past(set_v)) == '0));
    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(set_v) != '0));
endmodule

// File: rtl/eee_idle_fsm.sv
module eee_idle_fsm
    import eee_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lpi_en,
    input  logic lpi_auto,
    input  logic link_up,
    input  logic ls_met,
    input  logic tx_pending,
    input  logic wake_done,
    output logic wake_load,
    output logic ev_enter,
    output logic ev_exit,
    output logic tx_lpi,
    output logic tx_ready
);
    lpi_state_e cur_q, nxt;
    logic go_idle, leave_idle;

    assign go_idle    = lpi_en && lpi_auto && link_up && ls_met && !tx_pending;
    assign leave_idle = tx_pending || !lpi_en || !lpi_auto || !link_up;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= ST_ACTIVE;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_ACTIVE: if (go_idle)    nxt = ST_LPI;
            ST_LPI:    if (leave_idle) nxt = ST_WAKE;
            ST_WAKE:   if (wake_done)  nxt = ST_ACTIVE;
            default:                   nxt = ST_ACTIVE;
        endcase
    end

    always_comb begin
        tx_lpi    = (cur_q == ST_LPI);
        tx_ready  = (cur_q == ST_ACTIVE);
        ev_enter  = (cur_q == ST_ACTIVE) && (nxt == ST_LPI);
        ev_exit   = (cur_q == ST_LPI) && (nxt == ST_WAKE);
        wake_load = ev_exit;
    end

    // R3
    entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_lpi) |-> $past(lpi_en && lpi_auto && link_up && !tx_pending && ls_met));
    // R4
    pending_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lpi && tx_pending) |=> (!tx_lpi && !tx_ready));
    // R5
    forced_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lpi && (!link_up || !lpi_en)) |=> !tx_lpi);
    // R10
    ready_lpi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_lpi && tx_ready));
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
    import eee_pkg::*;
#(
    parameter int US_PER_MS = 1000,
    parameter int LS_W      = 11,
    parameter int TW_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              lpi_en,
    input  logic              lpi_auto,
    input  logic              link_up,
    input  logic [LS_W-1:0]   ls_ms,
    input  logic [TW_W-1:0]   tw_us,
    input  logic              tx_pending,
    input  logic              rx_lpi_enter,
    input  logic              rx_lpi_exit,
    input  logic              stat_rd,
    output logic              tx_lpi,
    output logic              tx_ready,
    output logic [EV_NUM-1:0] lpi_events,
    output logic              lpi_irq
);
    logic ls_met, wake_done, wake_load, ev_enter, ev_exit;
    logic [EV_NUM-1:0] set_v;

    eee_ls_timer #(.US_PER_MS(US_PER_MS), .LS_W(LS_W)) u_ls (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .link_up(link_up),
        .ls_ms(ls_ms), .ls_met(ls_met));

    eee_wake_timer #(.TW_W(TW_W)) u_tw (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .load(wake_load),
        .load_val(tw_us), .done(wake_done));

    eee_idle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en), .lpi_auto(lpi_auto),
        .link_up(link_up), .ls_met(ls_met), .tx_pending(tx_pending),
        .wake_done(wake_done), .wake_load(wake_load), .ev_enter(ev_enter),
        .ev_exit(ev_exit), .tx_lpi(tx_lpi), .tx_ready(tx_ready));

    always_comb begin
        set_v              = '0;
        set_v[EV_TX_ENTER] = ev_enter;
        set_v[EV_TX_EXIT]  = ev_exit;
        set_v[EV_RX_ENTER] = rx_lpi_enter;
        set_v[EV_RX_EXIT]  = rx_lpi_exit;
    end

    eee_event_reg #(.N(EV_NUM)) u_ev (
        .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr(stat_rd),
        .ev(lpi_events), .irq(lpi_irq));
endmodule

// File: tb/eee_lpi_ctrl_test.sv
module eee_lpi_ctrl_test;
    logic clk = 0, rst_n = 0, us_tick = 0;
    logic lpi_en = 0, lpi_auto = 0, link_up = 0, tx_pending = 0;
    logic rx_lpi_enter = 0, rx_lpi_exit = 0, stat_rd = 0;
    logic [10:0] ls_ms = '0;
    logic [15:0] tw_us = '0;
    logic tx_lpi, tx_ready, lpi_irq;
    logic [3:0] lpi_events;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    eee_lpi_ctrl #(.US_PER_MS(4)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .lpi_en(lpi_en),
        .lpi_auto(lpi_auto), .link_up(link_up), .ls_ms(ls_ms), .tw_us(tw_us),
        .tx_pending(tx_pending), .rx_lpi_enter(rx_lpi_enter),
        .rx_lpi_exit(rx_lpi_exit), .stat_rd(stat_rd), .tx_lpi(tx_lpi),
        .tx_ready(tx_ready), .lpi_events(lpi_events), .lpi_irq(lpi_irq));

    // bits: en, auto, pending, expected tx_lpi
    localparam logic [3:0] GATE_TBL [8] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0110,
        4'b1000, 4'b1010, 4'b1101, 4'b1110 };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            us_tick = 1; @(negedge clk);
            us_tick = 0; @(negedge clk);
        end
    endtask

    task automatic rd_clear();
        stat_rd = 1; @(negedge clk); stat_rd = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clks(3);
        // R1 reset state
        check({tx_ready, tx_lpi, lpi_irq}, 8'b100, "R1 outputs in reset");
        rst_n = 1; clks(1);
        check({4'b0, lpi_events}, 8'h0, "R1 events after reset");
        check({tx_ready, tx_lpi, lpi_irq}, 8'b100, "R10 ACTIVE after reset");

        // R3 gate table, ls_ms=0, tw_us=0, link good
        link_up = 1;
        for (int i = 0; i < 8; i++) begin
            {lpi_en, lpi_auto, tx_pending} = GATE_TBL[i][3:1];
            clks(2);
            check({7'b0, tx_lpi}, {7'b0, GATE_TBL[i][0]}, $sformatf("R3 gate pattern %0d", i));
            lpi_en = 0; tx_pending = 0; lpi_auto = 0;
            clks(3);
            rd_clear(); clks(1);
        end

        // R2 link-stable timing, ls=2 ms = 8 ticks
        ls_ms = 2; lpi_auto = 1; lpi_en = 1;
        link_up = 0; clks(2);
        link_up = 1;
        ticks(7); clks(1);
        check({7'b0, tx_lpi}, 8'h0, "R2 one tick short");
        ticks(1); clks(1);
        check({7'b0, tx_lpi}, 8'h1, "R2 at link-stable limit");
        check({4'b0, lpi_events}, 8'h1, "R7 tx enter event bit0");
        check({7'b0, lpi_irq}, 8'h1, "R7 irq while event held");
        rd_clear(); clks(1);
        check({3'b0, lpi_irq, lpi_events}, 8'h0, "R8 read clears events and irq");

        // R5 forced exit by link drop, R6 restart
        ticks(3);
        link_up = 0; clks(1);
        check({7'b0, tx_lpi}, 8'h0, "R5 exit on link drop");
        check({4'b0, lpi_events}, 8'h2, "R5 tx exit event bit1");
        clks(2); rd_clear();
        link_up = 1;
        ticks(7); clks(1);
        check({7'b0, tx_lpi}, 8'h0, "R6 count restarted after drop");
        ticks(1); clks(1);
        check({7'b0, tx_lpi}, 8'h1, "R6 reaches limit after restart");

        // R5 exit by clearing enable
        lpi_en = 0; clks(1);
        check({6'b0, tx_lpi, tx_ready}, 8'h0, "R5 exit on enable clear");
        clks(2);
        check({7'b0, tx_ready}, 8'h1, "R9 back to ACTIVE with tw=0");
        lpi_en = 1; clks(2);
        rd_clear(); clks(1);

        // R4 wake hold-off tw=3
        tw_us = 3;
        check({7'b0, tx_lpi}, 8'h1, "R4 precondition in idle");
        tx_pending = 1; clks(1);
        check({6'b0, tx_lpi, tx_ready}, 8'h0, "R4 leave on pending");
        ticks(2);
        check({7'b0, tx_ready}, 8'h0, "R4 still held after 2 ticks");
        ticks(1);
        check({7'b0, tx_ready}, 8'h1, "R4 ready after 3 ticks");
        check({7'b0, tx_lpi}, 8'h0, "R10 no idle while pending");

        // R9 tw=0 one-cycle wake
        tw_us = 0; tx_pending = 0; clks(1);
        check({7'b0, tx_lpi}, 8'h1, "R9 re-entered idle");
        tx_pending = 1; clks(1);
        check({7'b0, tx_ready}, 8'h0, "R9 wake cycle not ready");
        clks(1);
        check({7'b0, tx_ready}, 8'h1, "R9 ready after one cycle");
        lpi_en = 0; tx_pending = 0; clks(1);
        rd_clear(); clks(1);

        // R7 receive events, R8 collision on read
        rx_lpi_enter = 1; clks(1); rx_lpi_enter = 0;
        check({4'b0, lpi_events}, 8'h4, "R7 rx enter event bit2");
        rx_lpi_exit = 1; stat_rd = 1; clks(1);
        rx_lpi_exit = 0; stat_rd = 0;
        check({4'b0, lpi_events}, 8'h8, "R8 event wins over read clear");
        check({7'b0, lpi_irq}, 8'h1, "R7 irq held by rx exit");
        rd_clear(); clks(1);
        check({3'b0, lpi_irq, lpi_events}, 8'h0, "R8 cleared after second read");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule